// File: doc/BRIEF.md
# Store Slot Pool

The block keeps a small, fixed set of store slots. Each slot pairs an address register with a data buffer. Every store the decode stage issues must first own a slot. A store that covers several consecutive words is cut into double-word pieces, and each piece takes its own slot. The number of pieces depends on whether the first word is at an even or an odd word address.

While no slot is free, or while pieces of the current store remain beyond the one placed this cycle, the decode stage is held off by a combinational stall. Memory receives the slots oldest first over a valid/ready stream. A slot handed to memory comes back through a one-hot release pulse one cycle after the handshake, and it can be allocated again in the following cycle.

Stores issued under an unresolved branch carry a conditional mark and are held back from memory. An activate pulse clears the mark on every held slot. A cancel pulse throws the held slots away and returns them to the pool.

Top module: `store_slot_pool`

## Requirements
- R1: After reset all slots are free, `mem_valid` and `slot_release` are 0, and `st_stall` is 0 while `st_valid` is 0.
- R2: The pool holds SLOTS (default 3) slots. A piece always takes the lowest-numbered free slot, and `mem_slot` reports that number. A store presented while every slot is occupied is stalled.
- R3: A store of `st_words` words (1 to 16) starting at word address `st_addr` needs ((st_addr[0] + st_words + 1) >> 1) slots. Six words therefore need 3 slots from an even address and 4 from an odd one.
- R4: Piece k of a store is written to double-word address (st_addr >> 1) + k. Its `mem_mask` bit 0 marks the even word and bit 1 the odd word, and a bit is set only for words that belong to the store.
- R5: `mem_valid` presents the oldest allocated slot that has not yet been handed over. While `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_mask` and `mem_slot` hold steady. A transfer happens on a clock edge where both are high.
- R6: A slot allocated with `st_cond`=1 is never offered to memory while it is marked. `br_activate` clears the mark on all slots; the mark on a slot allocated in that same cycle is kept.
- R7: `br_cancel` frees every marked slot at the next edge and leaves unmarked slots untouched. If `br_cancel` and `br_activate` arrive together, the cancel wins.
- R8: `slot_release` is a one-hot pulse for the slot that transferred, asserted in the cycle after the handshake. That slot counts as free from the cycle after the pulse.
- R9: `st_stall` = `st_valid` AND NOT (a slot is free AND the piece being placed is the store's last). The decode stage holds its request steady while the stall is high. The store is taken in the cycle the stall is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| st_valid | input | 1 | Store request present |
| st_addr | input | ADDR_W | Word address of the first word |
| st_words | input | CNT_W | Number of words to store (1 to 16) |
| st_cond | input | 1 | Store issued under an unresolved branch |
| st_stall | output | 1 | Hold the request; combinational |
| br_activate | input | 1 | Branch resolved not taken: release marked slots to memory |
| br_cancel | input | 1 | Branch taken: discard marked slots |
| mem_valid | output | 1 | A slot is offered to memory |
| mem_ready | input | 1 | Memory accepts the offered slot |
| mem_addr | output | ADDR_W-1 | Double-word address of the offered slot |
| mem_mask | output | 2 | Word enables of the offered slot |
| mem_slot | output | IDX_W | Number of the offered slot |
| slot_release | output | SLOTS | One-hot free indication, one cycle after transfer |

## Verification
The allocation path is exercised with one- and two-word stores at even and odd addresses, and with six-word stores from both alignments. Together these separate the three- and four-slot cases and show the partial masks on the first and last pieces. Memory back-pressure is applied in three settings: held low until the pool fills, held high, and toggled pseudo-randomly. These show whether the stall, the oldest-first order and the steady offer under a low ready hold up when slots are recycled at different rates. Conditional stores are resolved both by activate and by cancel. This shows that held slots never leak to memory and that a cancel returns exactly the marked slots to the pool.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int WORDS_PER_DW = 2;

  typedef struct packed {
    logic vld;   // slot owned by a store piece
    logic cond;  // piece issued under an unresolved branch
    logic iss;   // handed to memory, waiting for release
    logic rel;   // release pulse pending
  } slot_flags_t;
endpackage

// File: rtl/ssp_split.sv
module ssp_split #(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [CNT_W-1:0]  st_words,
  input  logic              grant,
  output logic              last,
  output logic [ADDR_W-2:0] dw_addr,
  output logic [ssp_pkg::WORDS_PER_DW-1:0] mask
);
  localparam int PW = CNT_W + 2;

  logic [CNT_W-1:0] done_q;
  logic [PW-1:0]    off, span_end, pieces, lo_pos, hi_pos;

  always_comb begin
    off      = PW'(st_addr[0]);
    span_end = off + PW'(st_words);
    pieces   = (span_end + PW'(1)) >> 1;
    lo_pos   = PW'({done_q, 1'b0});
    hi_pos   = lo_pos + PW'(1);
    mask[0]  = (lo_pos >= off) && (lo_pos < span_end);
    mask[1]  = (hi_pos >= off) && (hi_pos < span_end);
    last     = (PW'(done_q) + PW'(1)) == pieces;
    dw_addr  = st_addr[ADDR_W-1:1] + (ADDR_W-1)'(done_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !st_valid) done_q <= '0;
    else if (grant)          done_q <= last ? '0 : done_q + CNT_W'(1);
  end
endmodule

// File: rtl/ssp_age.sv
module ssp_age #(
  parameter int N     = 3,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic [IDX_W-1:0] alloc_idx,
  input  logic [N-1:0]     vld,
  input  logic [N-1:0]     cand,
  output logic             head_any,
  output logic [IDX_W-1:0] head_idx
);
  // older_q[i][j] set: slot i was allocated before slot j
  logic [N-1:0] older_q [N];
  logic [N-1:0] is_old;

  for (genvar i = 0; i < N; i++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rst_n) older_q[i] <= '0;
      else if (alloc) begin
        for (int j = 0; j < N; j++) begin
          if (IDX_W'(i) == alloc_idx)      older_q[i][j] <= 1'b0;
          else if (IDX_W'(j) == alloc_idx) older_q[i][j] <= vld[i];
        end
      end
    end

    always_comb begin
      is_old[i] = cand[i];
      for (int j = 0; j < N; j++)
        if (j != i && cand[j] && older_q[j][i]) is_old[i] = 1'b0;
    end
  end

  always_comb begin
    head_any = |is_old;
    head_idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (is_old[i]) head_idx = IDX_W'(i);
  end
endmodule

// File: rtl/store_slot_pool.sv
module store_slot_pool
  import ssp_pkg::*;
#(
  parameter int SLOTS  = 3,
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 5,
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [CNT_W-1:0]  st_words,
  input  logic              st_cond,
  output logic              st_stall,
  input  logic              br_activate,
  input  logic              br_cancel,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-2:0] mem_addr,
  output logic [WORDS_PER_DW-1:0] mem_mask,
  output logic [IDX_W-1:0]  mem_slot,
  output logic [SLOTS-1:0]  slot_release
);
  slot_flags_t              flags_q [SLOTS];
  logic [ADDR_W-2:0]        addr_q  [SLOTS];
  logic [WORDS_PER_DW-1:0]  mask_q  [SLOTS];

  logic [SLOTS-1:0] slot_vld, slot_cond, slot_iss;
  logic             any_free, alloc_go, piece_last, head_any, xfer;
  logic [IDX_W-1:0] free_idx, head_idx;
  logic [ADDR_W-2:0] piece_addr;
  logic [WORDS_PER_DW-1:0] piece_mask;

  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = 0; i < SLOTS; i++) begin
      slot_vld[i]     = flags_q[i].vld;
      slot_cond[i]    = flags_q[i].cond;
      slot_iss[i]     = flags_q[i].iss;
      slot_release[i] = flags_q[i].rel;
    end
    for (int i = SLOTS - 1; i >= 0; i--)
      if (!flags_q[i].vld) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
  end

  assign alloc_go = st_valid && any_free;
  assign st_stall = st_valid && !(any_free && piece_last);

  ssp_split #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_split (
    .clk      (clk),
    .rst_n    (rst_n),
    .st_valid (st_valid),
    .st_addr  (st_addr),
    .st_words (st_words),
    .grant    (alloc_go),
    .last     (piece_last),
    .dw_addr  (piece_addr),
    .mask     (piece_mask)
  );

  ssp_age #(.N(SLOTS), .IDX_W(IDX_W)) u_age (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc     (alloc_go),
    .alloc_idx (free_idx),
    .vld       (slot_vld),
    .cand      (slot_vld & ~slot_iss),
    .head_any  (head_any),
    .head_idx  (head_idx)
  );

  assign mem_valid = head_any && !slot_cond[head_idx];
  assign mem_addr  = addr_q[head_idx];
  assign mem_mask  = mask_q[head_idx];
  assign mem_slot  = head_idx;
  assign xfer      = mem_valid && mem_ready;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic take, hand;
    assign take = alloc_go && (free_idx == IDX_W'(i));
    assign hand = xfer && (head_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) flags_q[i] <= '0;
      else begin
        flags_q[i].rel <= hand;
        if (take) begin
          flags_q[i].vld  <= 1'b1;
          flags_q[i].cond <= st_cond;
          flags_q[i].iss  <= 1'b0;
        end else if (flags_q[i].rel) begin
          flags_q[i].vld <= 1'b0;
          flags_q[i].iss <= 1'b0;
        end else if (hand) begin
          flags_q[i].iss <= 1'b1;
        end else if (br_cancel && flags_q[i].cond) begin
          flags_q[i].vld  <= 1'b0;
          flags_q[i].cond <= 1'b0;
        end else if (br_activate) begin
          flags_q[i].cond <= 1'b0;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (take) begin
        addr_q[i] <= piece_addr;
        mask_q[i] <= piece_mask;
      end
    end
  end
endmodule

// File: rtl/ssp_chk.sv
module ssp_chk #(
  parameter int SLOTS  = 3,
  parameter int ADDR_W = 24,
  parameter int IDX_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              st_valid,
  input logic              st_stall,
  input logic              br_activate,
  input logic              br_cancel,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-2:0] mem_addr,
  input logic [1:0]        mem_mask,
  input logic [IDX_W-1:0]  mem_slot,
  input logic [SLOTS-1:0]  slot_release,
  input logic [SLOTS-1:0]  vld,
  input logic [SLOTS-1:0]  cond,
  input logic              alloc
);
  assert_full_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && (&vld)) |-> st_stall);

  assert_offer_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_mask) && $stable(mem_slot)));

  assert_release_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready) |=> (slot_release == (SLOTS'(1) << $past(mem_slot))));

  assert_release_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_release));

  assert_cancel_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (br_cancel && !alloc) |=> ((vld & cond) == '0));

  assert_activate_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (br_activate && !alloc) |=> ((vld & cond) == '0));
endmodule

bind store_slot_pool ssp_chk #(.SLOTS(SLOTS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .st_valid     (st_valid),
  .st_stall     (st_stall),
  .br_activate  (br_activate),
  .br_cancel    (br_cancel),
  .mem_valid    (mem_valid),
  .mem_ready    (mem_ready),
  .mem_addr     (mem_addr),
  .mem_mask     (mem_mask),
  .mem_slot     (mem_slot),
  .slot_release (slot_release),
  .vld          (slot_vld),
  .cond         (slot_cond),
  .alloc        (alloc_go)
);

// File: tb/store_slot_pool_tb.sv
`timescale 1ns/1ps
module store_slot_pool_tb;
  localparam int SLOTS = 3, ADDR_W = 24, CNT_W = 5, IDX_W = 2;

  logic clk = 0, rst_n = 0;
  logic st_valid = 0, st_cond = 0, br_activate = 0, br_cancel = 0, mem_ready = 0;
  logic [ADDR_W-1:0] st_addr = '0;
  logic [CNT_W-1:0]  st_words = '0;
  logic st_stall, mem_valid;
  logic [ADDR_W-2:0] mem_addr;
  logic [1:0] mem_mask;
  logic [IDX_W-1:0] mem_slot;
  logic [SLOTS-1:0] slot_release;

  store_slot_pool #(.SLOTS(SLOTS), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dut (.*);

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, hs_cnt = 0, ready_mode = 0;

  // behavioural reference state
  bit m_vld[SLOTS], m_cond[SLOTS], m_iss[SLOTS], m_rel[SLOTS];
  int m_addr[SLOTS], m_mask[SLOTS];
  int order[$];
  int m_done = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic int pieces_of(int a, int w);
    return ((a % 2) + w + 1) / 2;
  endfunction

  function automatic int mask_of(int a, int w, int k);
    int m = 0;
    for (int p = 0; p < w; p++) begin
      int pos = (a % 2) + p;
      if (pos / 2 == k) m |= 1 << (pos % 2);
    end
    return m;
  endfunction

  function automatic int head_of();
    foreach (order[k]) if (m_vld[order[k]] && !m_iss[order[k]]) return order[k];
    return -1;
  endfunction

  function automatic int lowest_free();
    for (int i = 0; i < SLOTS; i++) if (!m_vld[i]) return i;
    return -1;
  endfunction

  function automatic void drop(int s);
    for (int k = 0; k < order.size(); k++)
      if (order[k] == s) begin order.delete(k); break; end
  endfunction

  // compare every cycle, away from the active edge
  always @(negedge clk) if (rst_n) begin
    int h, f, ev_stall, ev_mv, rel;
    f = lowest_free();
    ev_stall = st_valid && !(f >= 0 && m_done + 1 == pieces_of(int'(st_addr), int'(st_words)));
    h = head_of();
    ev_mv = (h >= 0) && !m_cond[h];
    chk("R9 st_stall", int'(st_stall), ev_stall);
    chk("R5/R6 mem_valid", int'(mem_valid), ev_mv);
    if (ev_mv) begin
      chk("R4 mem_addr", int'(mem_addr), m_addr[h]);
      chk("R4 mem_mask", int'(mem_mask), m_mask[h]);
      chk("R2/R5 mem_slot", int'(mem_slot), h);
    end
    rel = 0;
    for (int i = 0; i < SLOTS; i++) if (m_rel[i]) rel |= 1 << i;
    chk("R8 slot_release", int'(slot_release), rel);
  end

  // model update at the edge
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) begin
        m_vld[i] = 0; m_cond[i] = 0; m_iss[i] = 0; m_rel[i] = 0;
      end
      order.delete();
      m_done = 0;
    end else begin
      int h, f, a, w;
      bit hs, rel_next[SLOTS];
      h = head_of();
      f = lowest_free();
      a = int'(st_addr); w = int'(st_words);
      hs = (h >= 0) && !m_cond[h] && mem_ready;
      if (mem_valid && mem_ready) hs_cnt++;
      for (int i = 0; i < SLOTS; i++) rel_next[i] = 0;
      for (int i = 0; i < SLOTS; i++)
        if (m_rel[i]) begin m_vld[i] = 0; m_iss[i] = 0; drop(i); end
      if (hs) begin m_iss[h] = 1; rel_next[h] = 1; end
      if (br_cancel) begin
        for (int i = 0; i < SLOTS; i++)
          if (m_vld[i] && m_cond[i]) begin m_vld[i] = 0; m_cond[i] = 0; drop(i); end
      end else if (br_activate) begin
        for (int i = 0; i < SLOTS; i++) m_cond[i] = 0;
      end
      if (st_valid && f >= 0) begin
        m_vld[f] = 1; m_cond[f] = st_cond; m_iss[f] = 0;
        m_addr[f] = (a >> 1) + m_done;
        m_mask[f] = mask_of(a, w, m_done);
        order.push_back(f);
        m_done = (m_done + 1 == pieces_of(a, w)) ? 0 : m_done + 1;
      end else if (!st_valid) m_done = 0;
      for (int i = 0; i < SLOTS; i++) m_rel[i] = rel_next[i];
    end
  end

  // memory back-pressure
  always @(posedge clk) begin
    #1;
    mem_ready = (ready_mode == 1) || (ready_mode == 2 && $urandom_range(0, 1) == 1);
  end

  task automatic put(int a, int w, bit c);
    @(posedge clk); #1;
    st_valid = 1; st_addr = ADDR_W'(a); st_words = CNT_W'(w); st_cond = c;
    forever begin
      @(negedge clk);
      if (!st_stall) break;
    end
    @(posedge clk); #1;
    st_valid = 0;
  endtask

  task automatic pulse(bit act);
    @(posedge clk); #1;
    if (act) br_activate = 1; else br_cancel = 1;
    @(posedge clk); #1;
    br_activate = 0; br_cancel = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    fails++; checks++;
    $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 150000);
    finish_run();
  end

  initial begin
    int base;
    idle(3);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 mem_valid after reset", int'(mem_valid), 0);
    chk("R1 slot_release after reset", int'(slot_release), 0);
    chk("R1 st_stall after reset", int'(st_stall), 0);

    // single stores, both alignments
    ready_mode = 1;
    put(10, 1, 0); put(11, 1, 0); put(20, 2, 0); put(21, 2, 0);
    idle(6);

    // fill the pool with ready low; fourth store must stall (R2)
    ready_mode = 0;
    put(100, 1, 0); put(102, 1, 0); put(104, 1, 0);
    @(posedge clk); #1;
    st_valid = 1; st_addr = 106; st_words = 1; st_cond = 0;
    @(negedge clk);
    chk("R2 stall with pool full", int'(st_stall), 1);
    ready_mode = 1;
    forever begin @(negedge clk); if (!st_stall) break; end
    @(posedge clk); #1 st_valid = 0;
    idle(8);

    // six-word stores: 3 pieces aligned, 4 pieces misaligned (R3)
    base = hs_cnt;
    put(200, 6, 0); idle(8);
    chk("R3 slots for aligned six words", hs_cnt - base, 3);
    base = hs_cnt;
    put(301, 6, 0); idle(8);
    chk("R3 slots for misaligned six words", hs_cnt - base, 4);

    // conditional stores held, then activated (R6)
    base = hs_cnt;
    put(400, 1, 1); put(402, 2, 1);
    idle(5);
    chk("R6 marked slots held from memory", hs_cnt - base, 0);
    pulse(1); idle(8);
    chk("R6 activate lets slots drain", hs_cnt - base, 2);

    // conditional stores cancelled (R7)
    base = hs_cnt;
    put(500, 2, 1); put(503, 1, 1);
    pulse(0); idle(8);
    chk("R7 cancelled slots never transfer", hs_cnt - base, 0);
    ready_mode = 0;
    put(600, 1, 0); put(602, 1, 0); put(604, 1, 0);
    @(negedge clk);
    chk("R7 cancelled slots returned to pool", int'(mem_valid), 1);
    ready_mode = 1; idle(8);

    // mixed traffic with random back-pressure
    ready_mode = 2;
    for (int it = 0; it < 150; it++) begin
      if ($urandom_range(0, 3) == 0) begin
        put(2 * $urandom_range(0, 2000), $urandom_range(1, 2), 1);
        pulse($urandom_range(0, 1) == 1);
      end else begin
        put($urandom_range(0, 4095), $urandom_range(1, 16), 0);
      end
    end
    ready_mode = 1; idle(20);
    chk("R5 pool drained at end", int'(mem_valid), 0);
    finish_run();
  end
endmodule